// File: doc/BRIEF.md
# DMA Request-to-Channel Mapper

This block sits between the peripheral request lines of a chip and its DMA channels. Each request line has its own map register. Software uses a small register port to write into that register a channel number and an enable flag. The block samples the request levels and gives each channel the level of the request line that owns it. When the owning level changes, the block emits one-cycle strobes toward the channel status logic. A strobe to set "request-after-stop" marks a new request on an idle channel. Strobes to clear that flag and to set "end-of-receive" mark a request that went away.

When several enabled map registers name the same channel, the lowest-numbered request line owns that channel. The other lines mapped there have no effect on it. A write that enables a mapping to a channel number the instance does not have raises a sticky error flag. The register port also decodes three request-status addresses. These read as zero and discard writes.

Top module: `dmarq_mapper`

## Requirements
- R1: After reset every map register reads 0, `chan_req`, all strobes and `map_err` are 0.
- R2: Map register n (n < 64) is at byte offset 0x100 + 4·n. It stores bit 7 (enable) and bits 4:0 (channel number). Bits 6:5 and 31:8 read back as zero.
- R3: Map register n (64 ≤ n < NUM_REQ) is at byte offset 0x1100 + 4·(n−64), with the same fields. It routes its request line the same way as the low bank.
- R4: Offsets 0xE0, 0xE4 and 0xE8 read as zero. Writes to them change no map register and no flag. Any other unmapped offset also reads zero.
- R5: A request line whose map register has the enable bit clear does not affect any `chan_req` bit or any strobe.
- R6: A channel's `chan_req` bit equals the level of its owning request line. It follows that line two clock edges after the line changes: one edge for the input stage, one for the output register.
- R7: When the owning level rises while `chan_req` for that channel is 0, `ras_set` for that channel pulses for exactly one cycle. This happens in the same cycle that `chan_req` goes to 1.
- R8: When the owning level falls while `chan_req` is 1, `eor_set` and `ras_clr` for that channel pulse together for one cycle. This happens in the same cycle that `chan_req` goes to 0.
- R9: When two enabled map registers name the same channel, only the lower-numbered request line drives that channel.
- R10: A write that sets the enable bit with a channel number ≥ NUM_CH sets `map_err`. The flag stays set until reset. A write with the enable bit clear never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NUM_REQ | Peripheral request levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| chan_req | output | NUM_CH | Per-channel request level |
| ras_set | output | NUM_CH | Request-after-stop set strobe |
| ras_clr | output | NUM_CH | Request-after-stop clear strobe |
| eor_set | output | NUM_CH | End-of-receive set strobe |
| map_err | output | 1 | Sticky bad-mapping flag |

## Verification
Several corner cases are driven on purpose:
- Two lines are mapped to one channel, and the lower-priority line is toggled alone. A design that ORs the lines, or that lets the last match win, would raise the channel or emit a stray strobe.
- A high-bank register is placed at its split offset. An address decoder that treats the map as one contiguous block would store the value in the wrong register and route the wrong line.
- Two channels rise in the same cycle.
- A disabled register is written with an out-of-range channel.
- A mapping is cleared after an error, to show the flag does not clear itself.

Every strobe is matched against an ordered queue of expected events, so any extra or missing pulse is reported.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
   localparam int ADDR_W     = 16;
   localparam int DATA_W     = 32;
   localparam int CHF_W      = 5;             // channel field width in a map register
   localparam int IDX_W      = 7;             // map register index width
   localparam int BANK_CNT   = 64;            // registers per bank
   localparam logic [ADDR_W-1:0] LO_BASE = 16'h0100;
   localparam logic [ADDR_W-1:0] HI_BASE = 16'h1100;
   localparam logic [ADDR_W-1:0] STAT_A  = 16'h00E0;
   localparam logic [ADDR_W-1:0] STAT_B  = 16'h00E4;
   localparam logic [ADDR_W-1:0] STAT_C  = 16'h00E8;
   localparam int VLD_BIT    = 7;

   typedef struct packed {
      logic             hit;
      logic [IDX_W-1:0] idx;
   } map_sel_t;

   function automatic map_sel_t decode_map(input logic [ADDR_W-1:0] a);
      map_sel_t s;
      s.hit = 1'b0;
      s.idx = '0;
      if (a[1:0] == 2'b00) begin
         if (a >= LO_BASE && a < LO_BASE + ADDR_W'(4 * BANK_CNT)) begin
            s.hit = 1'b1;
            s.idx = {1'b0, a[7:2]};
         end else if (a >= HI_BASE && a < HI_BASE + ADDR_W'(4 * BANK_CNT)) begin
            s.hit = 1'b1;
            s.idx = {1'b1, a[7:2]};
         end
      end
      return s;
   endfunction

   function automatic logic is_status(input logic [ADDR_W-1:0] a);
      return (a == STAT_A) || (a == STAT_B) || (a == STAT_C);
   endfunction
endpackage

// File: rtl/dmarq_regfile.sv
module dmarq_regfile
   import dmarq_pkg::*;
#(
   parameter int NUM_REQ = 75,
   parameter int NUM_CH  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_we,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   output logic [NUM_REQ-1:0]            map_vld,
   output logic [NUM_REQ-1:0][CHF_W-1:0] map_ch,
   output logic                          map_err
);
   map_sel_t wsel;
   map_sel_t rsel;
   logic     wr_ok;
   logic     bad_ch;
   logic     unused_wbits;

   assign wsel   = decode_map(reg_addr);
   assign rsel   = wsel;
   assign wr_ok  = reg_we && wsel.hit && (int'(wsel.idx) < NUM_REQ);
   assign bad_ch = reg_wdata[VLD_BIT] && (int'(reg_wdata[CHF_W-1:0]) >= NUM_CH);
   assign unused_wbits = ^{reg_wdata[DATA_W-1:8], reg_wdata[6:5]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_vld <= '0;
         map_ch  <= '0;
         map_err <= 1'b0;
      end else if (wr_ok) begin
         map_vld[wsel.idx] <= reg_wdata[VLD_BIT];
         map_ch[wsel.idx]  <= reg_wdata[CHF_W-1:0];
         if (bad_ch) map_err <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (rsel.hit && (int'(rsel.idx) < NUM_REQ)) begin
         reg_rdata[VLD_BIT]     = map_vld[rsel.idx];
         reg_rdata[CHF_W-1:0]   = map_ch[rsel.idx];
      end
   end

   assert_err_sticky_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      map_err |=> map_err);

   assert_status_wr_ignored_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && is_status(reg_addr)) |=> ($stable(map_vld) && $stable(map_ch)));

   assert_status_reads_zero_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      is_status(reg_addr) |-> (reg_rdata == '0));
endmodule

// File: rtl/dmarq_route.sv
module dmarq_route
   import dmarq_pkg::*;
#(
   parameter int NUM_REQ = 75,
   parameter int NUM_CH  = 16
) (
   input  logic [NUM_REQ-1:0]            req_lvl,
   input  logic [NUM_REQ-1:0]            map_vld,
   input  logic [NUM_REQ-1:0][CHF_W-1:0] map_ch,
   output logic [NUM_CH-1:0]             ch_lvl
);
   // Scan from the top down so the lowest-numbered matching request is applied last.
   always_comb begin
      ch_lvl = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         for (int r = NUM_REQ - 1; r >= 0; r--) begin
            if (map_vld[r] && (map_ch[r] == CHF_W'(c))) ch_lvl[c] = req_lvl[r];
         end
      end
   end
endmodule

// File: rtl/dmarq_edge.sv
module dmarq_edge #(
   parameter int NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_lvl,
   output logic [NUM_CH-1:0] lvl_q,
   output logic [NUM_CH-1:0] ras_set_o,
   output logic [NUM_CH-1:0] ras_clr_o,
   output logic [NUM_CH-1:0] eor_set_o
);
   logic [NUM_CH-1:0] rise;
   logic [NUM_CH-1:0] fall;

   assign rise = ch_lvl & ~lvl_q;
   assign fall = ~ch_lvl & lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q     <= '0;
         ras_set_o <= '0;
         ras_clr_o <= '0;
         eor_set_o <= '0;
      end else begin
         lvl_q     <= ch_lvl;
         ras_set_o <= rise;
         ras_clr_o <= fall;
         eor_set_o <= fall;
      end
   end

   assert_ras_on_rise_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((ras_set_o & (~lvl_q | $past(lvl_q))) == '0));

   assert_eor_on_fall_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ((eor_set_o & (lvl_q | ~$past(lvl_q))) == '0));

   assert_eor_with_clr_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (eor_set_o == ras_clr_o));

   assert_set_clr_excl_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((ras_set_o & ras_clr_o) == '0));
endmodule

// File: rtl/dmarq_mapper.sv
module dmarq_mapper
   import dmarq_pkg::*;
#(
   parameter int NUM_REQ = 75,
   parameter int NUM_CH  = 16,
   parameter bit SYNC_IN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_in,
   input  logic               reg_we,
   input  logic [15:0]        reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic [NUM_CH-1:0]  chan_req,
   output logic [NUM_CH-1:0]  ras_set,
   output logic [NUM_CH-1:0]  ras_clr,
   output logic [NUM_CH-1:0]  eor_set,
   output logic               map_err
);
   localparam int MAX_REQ = 2 * BANK_CNT;
   localparam int MAX_CH  = 1 << CHF_W;

   if (NUM_REQ < 1 || NUM_REQ > MAX_REQ) begin : g_bad_req
      $error("dmarq_mapper: NUM_REQ out of range");
   end
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("dmarq_mapper: NUM_CH out of range");
   end

   logic [NUM_REQ-1:0]            req_s;
   logic [NUM_REQ-1:0]            map_vld;
   logic [NUM_REQ-1:0][CHF_W-1:0] map_ch;
   logic [NUM_CH-1:0]             ch_lvl;

   if (SYNC_IN) begin : g_in_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_s <= '0;
         else        req_s <= req_in;
      end
   end else begin : g_in_comb
      assign req_s = req_in;
   end

   dmarq_regfile #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .map_vld   (map_vld),
      .map_ch    (map_ch),
      .map_err   (map_err)
   );

   dmarq_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
      .req_lvl (req_s),
      .map_vld (map_vld),
      .map_ch  (map_ch),
      .ch_lvl  (ch_lvl)
   );

   dmarq_edge #(.NUM_CH(NUM_CH)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_lvl    (ch_lvl),
      .lvl_q     (chan_req),
      .ras_set_o (ras_set),
      .ras_clr_o (ras_clr),
      .eor_set_o (eor_set)
   );
endmodule

// File: tb/dmarq_mapper_tb_top.sv
module dmarq_mapper_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NREQ = 75;
   localparam int NCH  = 16;

   typedef struct packed {
      logic [1:0] kind;   // 0 = ras_set, 1 = ras_clr, 2 = eor_set
      logic [4:0] ch;
   } evt_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NREQ-1:0] req_in = '0;
   logic            reg_we = 1'b0;
   logic [15:0]     reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NCH-1:0]  chan_req, ras_set, ras_clr, eor_set;
   logic            map_err;

   int   n_chk = 0;
   int   n_err = 0;
   evt_t exp_q[$];
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmarq_mapper #(.NUM_REQ(NREQ), .NUM_CH(NCH)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .chan_req(chan_req), .ras_set(ras_set), .ras_clr(ras_clr),
      .eor_set(eor_set), .map_err(map_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic push(input logic [1:0] k, input int c);
      exp_q.push_back('{kind: k, ch: 5'(c)});
   endtask

   task automatic set_req(input int r, input logic v);
      req_in[r] = v;
      tick();
      tick();
   endtask

   // Monitor: pop one expected event for each strobe seen
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 3; k++) begin
               logic hitv;
               hitv = (k == 0) ? ras_set[c] : (k == 1) ? ras_clr[c] : eor_set[c];
               if (hitv) begin
                  evt_t got, want;
                  got = '{kind: 2'(k), ch: 5'(c)};
                  n_chk++;
                  if (exp_q.size() == 0) begin
                     n_err++;
                     $display("FAIL R5/R7/R8 unexpected strobe: actual kind=%0d ch=%0d expected none",
                              k, c);
                  end else begin
                     want = exp_q.pop_front();
                     if (got !== want) begin
                        n_err++;
                        $display("FAIL R7/R8 strobe: actual kind=%0d ch=%0d expected kind=%0d ch=%0d",
                                 got.kind, got.ch, want.kind, want.ch);
                     end
                  end
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk("R1 map0", 16'h0100, 32'h0);
      rd_chk("R1 map64", 16'h1100, 32'h0);
      rd_chk("R1 map74", 16'h1128, 32'h0);
      chk("R1 chan_req", 32'(chan_req), 32'h0);
      chk("R1 map_err", 32'(map_err), 32'h0);

      // R2 low bank, field masking; disabled high channel number no error (R10)
      wr(16'h010C, 32'hFFFF_FF7F);
      rd_chk("R2 map3 masked", 16'h010C, 32'h0000_001F);
      chk("R10 disabled no err", 32'(map_err), 32'h0);
      wr(16'h0114, 32'h0000_0082);
      rd_chk("R2 map5", 16'h0114, 32'h82);

      // R3 high bank
      wr(16'h1118, 32'h0000_0087);
      wr(16'h1100, 32'h0000_0084);
      rd_chk("R3 map70", 16'h1118, 32'h87);
      rd_chk("R3 map64", 16'h1100, 32'h84);
      rd_chk("R3 map6 untouched", 16'h0118, 32'h0);

      // R4 status addresses
      wr(16'h00E0, 32'hFFFF_FFFF);
      wr(16'h00E4, 32'hFFFF_FFFF);
      wr(16'h00E8, 32'hFFFF_FFFF);
      rd_chk("R4 stat0", 16'h00E0, 32'h0);
      rd_chk("R4 stat1", 16'h00E4, 32'h0);
      rd_chk("R4 stat2", 16'h00E8, 32'h0);
      rd_chk("R4 map5 kept", 16'h0114, 32'h82);
      rd_chk("R4 map0 kept", 16'h0100, 32'h0);
      chk("R4 map_err kept", 32'(map_err), 32'h0);
      rd_chk("R4 other offset", 16'h0200, 32'h0);

      // R5 disabled mappings are ignored
      set_req(3, 1'b1);
      set_req(10, 1'b1);
      chk("R5 chan_req idle", 32'(chan_req), 32'h0);
      set_req(3, 1'b0);
      set_req(10, 1'b0);

      // R6/R7/R8 basic rise and fall on ch2 via req5
      push(2'd0, 2);
      set_req(5, 1'b1);
      chk("R6 ch2 high", 32'(chan_req), 32'h0004);
      push(2'd1, 2); push(2'd2, 2);
      set_req(5, 1'b0);
      chk("R6 ch2 low", 32'(chan_req), 32'h0);

      // R3 routing of a high-bank line
      push(2'd0, 7);
      set_req(70, 1'b1);
      chk("R3 ch7 high", 32'(chan_req), 32'h0080);
      push(2'd1, 7); push(2'd2, 7);
      set_req(70, 1'b0);

      // R7 two channels rising in one cycle (ch2 then ch4 in monitor order)
      push(2'd0, 2); push(2'd0, 4);
      req_in[5] = 1'b1; req_in[64] = 1'b1;
      tick(); tick();
      chk("R7 dual rise", 32'(chan_req), 32'h0014);
      push(2'd1, 2); push(2'd2, 2); push(2'd1, 4); push(2'd2, 4);
      req_in[5] = 1'b0; req_in[64] = 1'b0;
      tick(); tick();
      chk("R8 dual fall", 32'(chan_req), 32'h0);

      // R9 priority: req8 also mapped to ch2, req5 wins
      wr(16'h0120, 32'h0000_0082);
      set_req(8, 1'b1);
      chk("R9 low-prio alone", 32'(chan_req), 32'h0);
      push(2'd0, 2);
      set_req(5, 1'b1);
      chk("R9 owner high", 32'(chan_req), 32'h0004);
      set_req(8, 1'b0);
      chk("R9 low-prio drop ignored", 32'(chan_req), 32'h0004);
      set_req(8, 1'b1);
      push(2'd1, 2); push(2'd2, 2);
      set_req(5, 1'b0);
      chk("R9 follows owner", 32'(chan_req), 32'h0);
      set_req(8, 1'b0);

      // R10 error flag
      wr(16'h0124, 32'h0000_008F);
      chk("R10 ch15 ok", 32'(map_err), 32'h0);
      wr(16'h0124, 32'h0000_0090);
      chk("R10 ch16 err", 32'(map_err), 32'h1);
      wr(16'h0124, 32'h0000_0000);
      tick();
      chk("R10 sticky", 32'(map_err), 32'h1);

      tick();
      chk("R7/R8 queue drained", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule